// File: doc/BRIEF.md
# Shifted Indexed Floating-Point Store Unit

This block turns one floating-point store request per clock into a memory write. Each request carries a base register value with its register-field number, an index register value, a 2-bit shift field and a 64-bit floating-point source value. The index value is shifted right (logically) by one more than the shift field. The result is then added to the base term to form the effective address.

The unit supports five store kinds. Two store a single-precision word. Two store a double-precision doubleword. One stores the raw low 32 bits of the source as an integer word. One single kind and one double kind also write the computed address back into the base register. The unit then presents the address, the byte count, the right-justified store data and a byte-enable mask. It also presents an optional base-register write and an illegal-form flag.

All outputs are registered one cycle after the request. No status state is kept between requests.

Top module: `fp_shift_store`

## Requirements
- R1: The store address equals the base term plus `rb_val` logically shifted right by (`sh_amt`+1) bit positions, taken modulo 2^64.
- R2: For the non-update kinds (codes 0, 2, 4), the base term is zero when `ra_idx` is 0. Otherwise it is `ra_val`.
- R3: For the update kinds (code 1 single, code 3 double), the base term is always `ra_val`. A legal update request asserts `ra_we` with `ra_wr_idx` = `ra_idx` and `ra_wr_data` equal to the store address.
- R4: An update kind whose `ra_idx` is 0 raises `illegal`, and it keeps both `st_valid` and `ra_we` low.
- R5: Kind codes 5, 6 and 7 raise `illegal`, and they keep both `st_valid` and `ra_we` low.
- R6: For single kinds (codes 0 and 1), a normal source whose unbiased exponent lies in -126..127 is stored as follows. `st_data[31]` holds the sign. `st_data[30:23]` holds the unbiased exponent + 127. `st_data[22:0]` holds source fraction bits 51..29. Bits 63..32 are zero.
- R7: For single kinds, a source of positive or negative zero is stored as a zero with the same sign, and `cvt_err` stays low.
- R8: For single kinds, any other source (out of range, denormal, infinity, NaN) sets `cvt_err` together with `st_valid`, and it stores a signed zero.
- R9: Double kinds (codes 2 and 3) store all 64 source bits unchanged, with `st_bytes` = 8 and `st_be` = 8'hFF.
- R10: The integer-word kind (code 4) stores source bits 31..0 unconverted in `st_data[31:0]`, with upper bits zero. Every 4-byte kind drives `st_bytes` = 4 and `st_be` = 8'h0F.
- R11: Outputs appear one clock after a request. A cycle with `req_valid` low gives `st_valid`, `ra_we`, `illegal` and `cvt_err` all low on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_kind | input | 3 | Store kind code 0..4 (5..7 illegal) |
| ra_idx | input | 5 | Base register field number |
| ra_val | input | 64 | Base register contents |
| rb_val | input | 64 | Index register contents |
| sh_amt | input | 2 | Shift field; index is shifted right by sh_amt+1 |
| frs_val | input | 64 | Floating-point source value |
| st_valid | output | 1 | Store is issued |
| st_addr | output | 64 | Effective address |
| st_bytes | output | 4 | Byte count, 4 or 8 |
| st_data | output | 64 | Right-justified store data |
| st_be | output | 8 | Byte-enable mask |
| ra_we | output | 1 | Base register write-back enable |
| ra_wr_idx | output | 5 | Write-back register number |
| ra_wr_data | output | 64 | Write-back value |
| illegal | output | 1 | Illegal form or kind |
| cvt_err | output | 1 | Single conversion out of range |

## Verification
Every cycle, the assertions check the following rules. An illegal form never issues a store or a write-back. The byte count matches the enable mask. A write-back always carries the store address to a non-zero register. A range error always comes with a signed-zero store. No output pulse appears without a request the cycle before. The actual numeric results are shown only by the bench's scenarios. These are the shifted-address sums including wrap-around, the zero base for field 0, the exponent rebias at its two range edges, and the raw low-word pass-through. The bench compares them against a reference model.

// File: rtl/fpss_pkg.sv
package fpss_pkg;
  localparam int XLEN      = 64;
  localparam int SH_W      = 2;
  localparam int REG_IDX_W = 5;

  typedef enum logic [2:0] {
    K_SGL     = 3'd0,
    K_SGL_UPD = 3'd1,
    K_DBL     = 3'd2,
    K_DBL_UPD = 3'd3,
    K_INTW    = 3'd4
  } st_kind_e;

  // shifted index added to base, wraps naturally
  function automatic logic [XLEN-1:0] ea_calc(input logic [XLEN-1:0] base,
                                               input logic [XLEN-1:0] idx,
                                               input logic [SH_W-1:0] sh);
    logic [SH_W:0] amt;
    amt = {1'b0, sh} + 1'b1;
    return base + (idx >> amt);
  endfunction

  // double -> single for normal in-range values; err otherwise
  function automatic logic [32:0] to_single(input logic [63:0] d);
    logic [10:0] e11;
    logic        zero;
    e11  = d[62:52];
    zero = (d[62:0] == 63'd0);
    if (zero)
      return {1'b0, d[63], 31'd0};
    else if (e11 >= 11'd897 && e11 <= 11'd1150)
      return {1'b0, d[63], 8'(e11 - 11'd896), d[51:29]};
    else
      return {1'b1, d[63], 31'd0};
  endfunction
endpackage

// File: rtl/fpss_addr_gen.sv
module fpss_addr_gen
  import fpss_pkg::*;
#(
  parameter int AW = XLEN,
  parameter int SW = SH_W,
  parameter int IW = REG_IDX_W
) (
  input  logic          upd,
  input  logic [IW-1:0] ra_idx,
  input  logic [AW-1:0] ra_val,
  input  logic [AW-1:0] rb_val,
  input  logic [SW-1:0] sh_amt,
  output logic [AW-1:0] ea,
  output logic          ra_zero
);
  logic [AW-1:0] base;
  logic [SW:0]   amt;

  always_comb begin
    ra_zero = (ra_idx == '0);
    base    = (upd || !ra_zero) ? ra_val : '0;
    amt     = {1'b0, sh_amt} + 1'b1;
    ea      = base + (rb_val >> amt);
  end
endmodule

// File: rtl/fpss_sgl_conv.sv
module fpss_sgl_conv
  import fpss_pkg::*;
(
  input  logic [63:0] dbl_in,
  output logic [31:0] sgl_out,
  output logic        range_err
);
  logic [32:0] res;
  always_comb begin
    res       = to_single(dbl_in);
    range_err = res[32];
    sgl_out   = res[31:0];
  end
endmodule

// File: rtl/fpss_data_fmt.sv
module fpss_data_fmt #(
  parameter int DW = 64,
  localparam int NB = DW / 8,
  localparam int CW = $clog2(NB + 1)
) (
  input  logic          wide,
  input  logic          raw_word,
  input  logic [DW-1:0] src,
  input  logic [31:0]   sgl,
  output logic [DW-1:0] data,
  output logic [CW-1:0] nbytes,
  output logic [NB-1:0] be
);
  always_comb begin
    if (wide) begin
      data   = src;
      nbytes = CW'(NB);
    end else begin
      data   = {{(DW-32){1'b0}}, raw_word ? src[31:0] : sgl};
      nbytes = CW'(4);
    end
  end

  for (genvar i = 0; i < NB; i++) begin : g_lane
    assign be[i] = (CW'(i) < nbytes);
  end
endmodule

// File: rtl/fp_shift_store.sv
module fp_shift_store
  import fpss_pkg::*;
#(
  parameter int AW = XLEN,
  parameter int SW = SH_W,
  parameter int IW = REG_IDX_W,
  localparam int NB = AW / 8,
  localparam int CW = $clog2(NB + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [2:0]    req_kind,
  input  logic [IW-1:0] ra_idx,
  input  logic [AW-1:0] ra_val,
  input  logic [AW-1:0] rb_val,
  input  logic [SW-1:0] sh_amt,
  input  logic [AW-1:0] frs_val,
  output logic          st_valid,
  output logic [AW-1:0] st_addr,
  output logic [CW-1:0] st_bytes,
  output logic [AW-1:0] st_data,
  output logic [NB-1:0] st_be,
  output logic          ra_we,
  output logic [IW-1:0] ra_wr_idx,
  output logic [AW-1:0] ra_wr_data,
  output logic          illegal,
  output logic          cvt_err
);
  logic          k_upd, k_sgl, k_wide, k_intw, k_bad;
  logic          ra_zero, rng_err, bad_form, fire;
  logic [AW-1:0] ea;
  logic [31:0]   sgl_w;
  logic [AW-1:0] fmt_data;
  logic [CW-1:0] fmt_bytes;
  logic [NB-1:0] fmt_be;

  always_comb begin
    k_upd  = 1'b0; k_sgl = 1'b0; k_wide = 1'b0; k_intw = 1'b0; k_bad = 1'b0;
    case (req_kind)
      K_SGL:     k_sgl = 1'b1;
      K_SGL_UPD: begin k_sgl = 1'b1; k_upd = 1'b1; end
      K_DBL:     k_wide = 1'b1;
      K_DBL_UPD: begin k_wide = 1'b1; k_upd = 1'b1; end
      K_INTW:    k_intw = 1'b1;
      default:   k_bad = 1'b1;
    endcase
  end

  fpss_addr_gen #(.AW(AW), .SW(SW), .IW(IW)) u_addr (
    .upd(k_upd), .ra_idx(ra_idx), .ra_val(ra_val), .rb_val(rb_val),
    .sh_amt(sh_amt), .ea(ea), .ra_zero(ra_zero)
  );

  fpss_sgl_conv u_conv (.dbl_in(frs_val), .sgl_out(sgl_w), .range_err(rng_err));

  fpss_data_fmt #(.DW(AW)) u_fmt (
    .wide(k_wide), .raw_word(k_intw), .src(frs_val), .sgl(sgl_w),
    .data(fmt_data), .nbytes(fmt_bytes), .be(fmt_be)
  );

  assign bad_form = req_valid && (k_bad || (k_upd && ra_zero));
  assign fire     = req_valid && !bad_form;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_valid   <= 1'b0;
      ra_we      <= 1'b0;
      illegal    <= 1'b0;
      cvt_err    <= 1'b0;
      st_addr    <= '0;
      st_bytes   <= '0;
      st_data    <= '0;
      st_be      <= '0;
      ra_wr_idx  <= '0;
      ra_wr_data <= '0;
    end else begin
      st_valid <= fire;
      ra_we    <= fire && k_upd;
      illegal  <= bad_form;
      cvt_err  <= fire && k_sgl && rng_err;
      if (req_valid) begin
        st_addr    <= ea;
        st_bytes   <= fmt_bytes;
        st_data    <= fmt_data;
        st_be      <= fmt_be;
        ra_wr_idx  <= ra_idx;
        ra_wr_data <= ea;
      end
    end
  end
endmodule

// File: rtl/fpss_checker.sv
module fpss_checker #(
  parameter int AW = 64,
  parameter int IW = 5,
  parameter int NB = 8,
  parameter int CW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          st_valid,
  input logic [AW-1:0] st_addr,
  input logic [CW-1:0] st_bytes,
  input logic [AW-1:0] st_data,
  input logic [NB-1:0] st_be,
  input logic          ra_we,
  input logic [IW-1:0] ra_wr_idx,
  input logic [AW-1:0] ra_wr_data,
  input logic          illegal,
  input logic          cvt_err
);
  assert_illegal_blocks_R4: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (!st_valid && !ra_we));

  assert_bad_kind_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> !cvt_err);

  assert_writeback_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ra_we |-> (st_valid && ra_wr_data == st_addr && ra_wr_idx != '0));

  assert_bytes_match_be_R10: assert property (@(posedge clk) disable iff (!rst_n)
    st_valid |-> (st_bytes == CW'($countones(st_be)) && (st_be == 8'h0F || st_be == 8'hFF)));

  assert_wide_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && st_bytes == CW'(4)) |-> (st_data[AW-1:32] == '0));

  assert_err_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cvt_err |-> (st_valid && st_data == {32'd0, st_data[31], 31'd0}));

  assert_latency_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid || illegal) |-> $past(req_valid));
endmodule

bind fp_shift_store fpss_checker #(.AW(AW), .IW(IW), .NB(NB), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .st_valid(st_valid),
  .st_addr(st_addr), .st_bytes(st_bytes), .st_data(st_data), .st_be(st_be),
  .ra_we(ra_we), .ra_wr_idx(ra_wr_idx), .ra_wr_data(ra_wr_data),
  .illegal(illegal), .cvt_err(cvt_err)
);

// File: tb/fp_shift_store_tb.sv
`timescale 1ns/1ps
module fp_shift_store_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [2:0]  req_kind = '0;
  logic [4:0]  ra_idx = '0;
  logic [63:0] ra_val = '0, rb_val = '0, frs_val = '0;
  logic [1:0]  sh_amt = '0;
  logic        st_valid, ra_we, illegal, cvt_err;
  logic [63:0] st_addr, st_data, ra_wr_data;
  logic [3:0]  st_bytes;
  logic [7:0]  st_be;
  logic [4:0]  ra_wr_idx;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  fp_shift_store u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
    .ra_idx(ra_idx), .ra_val(ra_val), .rb_val(rb_val), .sh_amt(sh_amt),
    .frs_val(frs_val), .st_valid(st_valid), .st_addr(st_addr),
    .st_bytes(st_bytes), .st_data(st_data), .st_be(st_be), .ra_we(ra_we),
    .ra_wr_idx(ra_wr_idx), .ra_wr_data(ra_wr_data), .illegal(illegal),
    .cvt_err(cvt_err)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Reference model: behavioural, integer-based
  function automatic void model(input int kind, input int idx, input logic [63:0] ra,
                                input logic [63:0] rb, input int sh, input logic [63:0] f,
                                output bit bad, output bit upd, output logic [63:0] ea,
                                output logic [63:0] data, output int nb, output bit err);
    logic [63:0] base, shifted;
    int unb;
    upd = (kind == 1 || kind == 3);
    bad = (kind > 4) || (upd && idx == 0);
    base = (upd || idx != 0) ? ra : 64'd0;
    shifted = rb;
    for (int i = 0; i <= sh; i++) shifted = shifted / 2;
    ea = base + shifted;
    err = 0;
    nb = (kind == 2 || kind == 3) ? 8 : 4;
    if (nb == 8) data = f;
    else if (kind == 4) data = {32'd0, f[31:0]};
    else begin
      unb = int'(f[62:52]) - 1023;
      if (f[62:0] == 0) data = {32'd0, f[63], 31'd0};
      else if (unb >= -126 && unb <= 127)
        data = {32'd0, f[63], 8'(unb + 127), f[51:29]};
      else begin
        data = {32'd0, f[63], 31'd0};
        err = 1;
      end
    end
  endfunction

  task automatic do_req(input string tag, input int kind, input int idx,
                        input logic [63:0] ra, input logic [63:0] rb,
                        input int sh, input logic [63:0] f);
    bit bad, upd, err; logic [63:0] ea, data; int nb;
    model(kind, idx, ra, rb, sh, f, bad, upd, ea, data, nb, err);
    @(negedge clk);
    req_valid = 1; req_kind = 3'(kind); ra_idx = 5'(idx);
    ra_val = ra; rb_val = rb; sh_amt = 2'(sh); frs_val = f;
    @(posedge clk); #1;
    req_valid = 0;
    check({tag, " illegal"}, 64'(illegal), 64'(bad));
    check({tag, " st_valid"}, 64'(st_valid), 64'(!bad));
    check({tag, " ra_we"}, 64'(ra_we), 64'(!bad && upd));
    if (!bad) begin
      check({tag, " addr"}, st_addr, ea);
      check({tag, " data"}, st_data, data);
      check({tag, " bytes"}, 64'(st_bytes), 64'(nb));
      check({tag, " be"}, 64'(st_be), (nb == 8) ? 64'hFF : 64'h0F);
      check({tag, " cvt_err"}, 64'(cvt_err), 64'(err));
      if (upd) begin
        check({tag, " wr_data"}, ra_wr_data, ea);
        check({tag, " wr_idx"}, 64'(ra_wr_idx), 64'(idx));
      end
    end
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R11 reset st_valid", 64'(st_valid), 0);
    check("R11 reset illegal", 64'(illegal), 0);
    rst_n = 1;
    do_req("R1 R6 single 1.0", 0, 3, 64'h1000, 64'h40, 0, 64'h3FF0000000000000);
    check("R6 literal 1.0", st_data, 64'h3F800000);
    do_req("R2 zero base", 0, 0, 64'hDEAD_0000, 64'h100, 1, 64'hC000000000000000);
    check("R2 literal addr", st_addr, 64'h40);
    do_req("R9 double sh3", 2, 9, 64'h2000, 64'hFF0, 3, 64'h7FF8_1234_5678_9ABC);
    do_req("R10 int word", 4, 2, 64'h10, 64'h8, 2, 64'hAAAA_BBBB_1234_5678);
    check("R10 literal data", st_data, 64'h1234_5678);
    do_req("R3 single update", 1, 7, 64'h5000, 64'h20, 0, 64'h4000000000000000);
    do_req("R3 double update", 3, 31, 64'h7000, 64'hFFFF_FFFF_FFFF_FFFF, 3, 64'h1);
    check("R3 literal wr", ra_wr_data, 64'h1000_0000_0000_6FFF);
    do_req("R4 update ra0", 1, 0, 64'h5000, 64'h20, 0, 64'h3FF0000000000000);
    do_req("R4 dbl update ra0", 3, 0, 64'h5000, 64'h20, 0, 64'h3FF0000000000000);
    do_req("R5 kind5", 5, 4, 64'h0, 64'h0, 0, 64'h0);
    do_req("R5 kind7", 7, 4, 64'h0, 64'h0, 0, 64'h0);
    do_req("R7 neg zero", 0, 1, 64'h0, 64'h0, 0, 64'h8000000000000000);
    check("R7 literal", st_data, 64'h8000_0000);
    do_req("R8 too large", 0, 1, 64'h0, 64'h0, 0, 64'h7E37E43C8800759C);
    check("R8 literal err", 64'(cvt_err), 1);
    do_req("R8 denormal", 1, 1, 64'h0, 64'h0, 0, 64'h0000000000000001);
    do_req("R8 exp 896", 0, 1, 64'h0, 64'h0, 0, {1'b0, 11'd896, 52'h5});
    do_req("R6 exp 897", 0, 1, 64'h0, 64'h0, 0, {1'b1, 11'd897, 52'hF_FFFF_FFFF_FFFF});
    do_req("R6 exp 1150", 0, 1, 64'h0, 64'h0, 0, {1'b0, 11'd1150, 52'h8_0000_2000_0000});
    do_req("R8 exp 1151", 0, 1, 64'h0, 64'h0, 0, {1'b0, 11'd1151, 52'h0});
    do_req("R1 wrap", 2, 5, 64'hFFFF_FFFF_FFFF_FFF0, 64'h40, 1, 64'h55);
    check("R1 literal wrap", st_addr, 64'h0);
    for (int k = 0; k < 40; k++)
      do_req("R1 sweep", k % 5, k % 3, 64'(k) * 64'h1_0001, 64'h8000_0000_0000_0000 >> k,
             k % 4, {1'b0, 11'(880 + k * 7), 52'(k * 12345)});
    @(negedge clk);
    @(posedge clk); #1;
    check("R11 idle st_valid", 64'(st_valid), 0);
    check("R11 idle ra_we", 64'(ra_we), 0);
    check("R11 idle illegal", 64'(illegal), 0);
    check("R11 idle cvt_err", 64'(cvt_err), 0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule